// File: doc/BRIEF.md
# Overlapping Register Window File

A register file for a 32-bit processor core in which every procedure addresses 32 logical registers, but only some of them name fixed storage. A low group of logical numbers selects a global bank that is the same in every window. The rest pass through a current-window pointer into a circular physical array. Each window holds an incoming group, a private local group and an outgoing group. The outgoing group of window w is the same storage as the incoming group of window w+1. When the caller loads arguments into its outgoing registers and issues a call, the callee finds them in its incoming registers. Results written there by the callee show up in the caller's outgoing registers after the return. No data is copied in either direction.

The block has two combinational read ports and one write port, all addressed by logical register number. A call strobe moves the pointer forward by one window and a return strobe moves it back. The block counts the windows that are resident. A call that would need a window not yet saved raises an overflow flag, and a return from the oldest resident window raises an underflow flag. In both cases the pointer stays where it is, and saving or restoring windows is left to surrounding logic. The default shape is 8 windows of 16 unique registers plus 10 globals, 138 words in all. A second shape, set by parameters, is 6 windows of 10 unique registers plus 18 globals, 78 words in all.

Top module: `rwin_regfile`

## Requirements
- R1: After reset the current window is 0, exactly one window is resident, and every register reads 0.
- R2: Logical register 0 always reads 0, and a write to it changes no register.
- R3: Logical registers below the global count (0 to 9 by default) name one shared bank, so a value written in one window reads back unchanged in every other window.
- R4: Local registers (logical 16 to 25 by default) are private to their window. A value written in one window is not visible in the next window, and it is visible again after returning.
- R5: A value written to outgoing register 26+k before a call reads back from incoming register 10+k after the call, for k from 0 to 5 (default shape).
- R6: A value the callee writes to incoming register 10+k reads back from the caller's outgoing register 26+k after the return.
- R7: A read returns the register's contents from before a write in the same cycle. A call or return takes effect at the clock edge, and reads in the strobe cycle still use the old window.
- R8: A call while the resident count equals the window count minus one drives ovf_o high in that same cycle, and the window does not change.
- R9: A return while only one window is resident drives unf_o high in that same cycle, and the window does not change.
- R10: When call and return are both high in the same cycle, neither one acts and neither flag rises.
- R11: With 6 windows, 18 globals, overlap 4 and locals 6, logical 17 is a global, outgoing 28 maps onto the callee's incoming 18, and the sixth resident window raises overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| call_i | input | 1 | Call strobe: advance the window |
| ret_i | input | 1 | Return strobe: go back one window |
| ra_addr | input | 5 | Logical register number for read port A |
| rb_addr | input | 5 | Logical register number for read port B |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Logical register number for the write |
| wr_data | input | XLEN | Write data |
| ra_data | output | XLEN | Read data for port A |
| rb_data | output | XLEN | Read data for port B |
| ovf_o | output | 1 | Call refused, window overflow |
| unf_o | output | 1 | Return refused, window underflow |

## Verification
The mapping is tested with writes to each logical group followed by reads after a call, after a return, and after a refused strobe.

- Globals read back the same in every window.
- Locals read back as zero in a fresh window.
- Outgoing and incoming registers show the overlap in both directions.

Together these patterns tell apart a pointer that moved, one that stayed and one that moved by the wrong amount. Same-cycle write-and-read and strobe-and-read steps show whether reads come before the edge. The bench walks the window pointer up to overflow and back down to underflow, and then sends a call and a return together, which separates the flag logic from the pointer update. A second instance in the small shape checks that the group boundaries follow the parameters rather than fixed numbers.

// File: rtl/rwf_pkg.sv
package rwf_pkg;

  typedef enum logic [1:0] {SEG_GLOB, SEG_IN, SEG_LOC, SEG_OUT} seg_e;

  // Which logical group a register number belongs to
  function automatic seg_e seg_of(int unsigned lr, int unsigned ng,
                                  int unsigned no, int unsigned nl);
    if (lr < ng)                return SEG_GLOB;
    else if (lr < ng + no)      return SEG_IN;
    else if (lr < ng + no + nl) return SEG_LOC;
    else                        return SEG_OUT;
  endfunction

  function automatic int unsigned wrap_inc(int unsigned w, int unsigned n);
    return (w + 1 == n) ? 0 : w + 1;
  endfunction

  function automatic int unsigned wrap_dec(int unsigned w, int unsigned n);
    return (w == 0) ? n - 1 : w - 1;
  endfunction

  // Physical slot: windows laid out first, global bank after them
  function automatic int unsigned phys_of(int unsigned lr, int unsigned w,
                                          int unsigned nwin, int unsigned ng,
                                          int unsigned no, int unsigned nl);
    int unsigned u;
    u = no + nl;
    case (seg_of(lr, ng, no, nl))
      SEG_GLOB: return nwin * u + lr;
      SEG_IN:   return w * u + (lr - ng);
      SEG_LOC:  return w * u + no + (lr - ng - no);
      default:  return wrap_inc(w, nwin) * u + (lr - ng - no - nl);
    endcase
  endfunction

endpackage

// File: rtl/rwf_addr_map.sv
module rwf_addr_map #(
  parameter int unsigned NWIN  = 8,
  parameter int unsigned NGLOB = 10,
  parameter int unsigned NOVL  = 6,
  parameter int unsigned NLOC  = 10,
  parameter int unsigned LAW   = 5,
  parameter int unsigned CW    = 3,
  parameter int unsigned PAW   = 8
) (
  input  logic [CW-1:0]  cwp_i,
  input  logic [LAW-1:0] lreg_i,
  output logic [PAW-1:0] preg_o
);
  import rwf_pkg::*;

  localparam int unsigned GBASE = NWIN * (NOVL + NLOC);

  seg_e seg;

  assign seg    = seg_of(32'(lreg_i), NGLOB, NOVL, NLOC);
  assign preg_o = PAW'(phys_of(32'(lreg_i), 32'(cwp_i), NWIN, NGLOB, NOVL, NLOC));

  always_comb begin
    if (!$isunknown(lreg_i) && !$isunknown(cwp_i)) begin
      // R3
      glob_bank_chk: assert ((seg == SEG_GLOB) == (32'(preg_o) >= GBASE))
        else $error("global group and global bank disagree");
    end
  end

endmodule

// File: rtl/rwf_window_ctl.sv
module rwf_window_ctl #(
  parameter int unsigned NWIN = 8,
  parameter int unsigned CW   = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          call_i,
  input  logic          ret_i,
  output logic [CW-1:0] cwp_o,
  output logic          ovf_o,
  output logic          unf_o
);
  import rwf_pkg::*;

  localparam int unsigned CNW = $clog2(NWIN + 1);
  localparam logic [CNW-1:0] CNT_MAX = CNW'(NWIN - 1);
  localparam logic [CNW-1:0] CNT_ONE = CNW'(1);

  logic [CW-1:0]  cwp;
  logic [CNW-1:0] cnt;
  logic full, empty, lone_call, lone_ret, adv, back;

  assign full      = (cnt == CNT_MAX);
  assign empty     = (cnt == CNT_ONE);
  assign lone_call = call_i & ~ret_i;
  assign lone_ret  = ret_i & ~call_i;
  assign adv       = lone_call & ~full;
  assign back      = lone_ret & ~empty;
  assign ovf_o     = lone_call & full;
  assign unf_o     = lone_ret & empty;
  assign cwp_o     = cwp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cwp <= '0;
      cnt <= CNT_ONE;
    end else if (adv) begin
      cwp <= CW'(wrap_inc(32'(cwp), NWIN));
      cnt <= cnt + CNT_ONE;
    end else if (back) begin
      cwp <= CW'(wrap_dec(32'(cwp), NWIN));
      cnt <= cnt - CNT_ONE;
    end
  end

  // R1
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt >= CNT_ONE) && (cnt <= CNT_MAX));

  // R5
  call_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (cwp != $past(cwp)));

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> $stable(cwp) && $stable(cnt));

  // R9
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unf_o |=> $stable(cwp) && $stable(cnt));

  // R10
  both_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (call_i && ret_i) |=> $stable(cwp));

endmodule

// File: rtl/rwf_storage.sv
module rwf_storage #(
  parameter int unsigned PHYS  = 138,
  parameter int unsigned PAW   = 8,
  parameter int unsigned XLEN  = 32,
  parameter int unsigned ZSLOT = 128
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we_i,
  input  logic [PAW-1:0]  wa_i,
  input  logic [XLEN-1:0] wd_i,
  input  logic [PAW-1:0]  ra_i,
  input  logic [PAW-1:0]  rb_i,
  output logic [XLEN-1:0] rda_o,
  output logic [XLEN-1:0] rdb_o
);
  logic [XLEN-1:0] arr [PHYS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < PHYS; i++) arr[i] <= '0;
    end else if (we_i) begin
      arr[wa_i] <= wd_i;
    end
  end

  // Flops hold old contents until the edge, so reads precede a same-cycle write
  assign rda_o = arr[ra_i];
  assign rdb_o = arr[rb_i];

  // R2
  zero_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |-> (32'(wa_i) != ZSLOT));

endmodule

// File: rtl/rwin_regfile.sv
module rwin_regfile #(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned NWIN  = 8,
  parameter int unsigned NGLOB = 10,
  parameter int unsigned NOVL  = 6,
  parameter int unsigned NLOC  = 10,
  parameter int unsigned LAW   = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            call_i,
  input  logic            ret_i,
  input  logic [LAW-1:0]  ra_addr,
  input  logic [LAW-1:0]  rb_addr,
  input  logic            wr_en,
  input  logic [LAW-1:0]  wr_addr,
  input  logic [XLEN-1:0] wr_data,
  output logic [XLEN-1:0] ra_data,
  output logic [XLEN-1:0] rb_data,
  output logic            ovf_o,
  output logic            unf_o
);
  localparam int unsigned UNIQ  = NOVL + NLOC;
  localparam int unsigned PHYS  = NWIN * UNIQ + NGLOB;
  localparam int unsigned PAW   = $clog2(PHYS);
  localparam int unsigned CW    = (NWIN > 1) ? $clog2(NWIN) : 1;
  localparam int unsigned ZSLOT = NWIN * UNIQ;
  localparam int unsigned NPORT = 3;

  logic [CW-1:0]  cwp;
  logic [LAW-1:0] lreg_v [NPORT];
  logic [PAW-1:0] preg_v [NPORT];
  logic           wr_live;

  assign lreg_v[0] = ra_addr;
  assign lreg_v[1] = rb_addr;
  assign lreg_v[2] = wr_addr;
  assign wr_live   = wr_en && (wr_addr != '0);

  rwf_window_ctl #(.NWIN(NWIN), .CW(CW)) u_ctl (
    .clk(clk), .rst_n(rst_n), .call_i(call_i), .ret_i(ret_i),
    .cwp_o(cwp), .ovf_o(ovf_o), .unf_o(unf_o)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_map
    rwf_addr_map #(
      .NWIN(NWIN), .NGLOB(NGLOB), .NOVL(NOVL), .NLOC(NLOC),
      .LAW(LAW), .CW(CW), .PAW(PAW)
    ) u_map (
      .cwp_i(cwp), .lreg_i(lreg_v[p]), .preg_o(preg_v[p])
    );
  end

  rwf_storage #(.PHYS(PHYS), .PAW(PAW), .XLEN(XLEN), .ZSLOT(ZSLOT)) u_store (
    .clk(clk), .rst_n(rst_n), .we_i(wr_live), .wa_i(preg_v[2]), .wd_i(wr_data),
    .ra_i(preg_v[0]), .rb_i(preg_v[1]), .rda_o(ra_data), .rdb_o(rb_data)
  );

endmodule

// File: tb/rwin_regfile_tb.sv
module rwin_regfile_tb;
  localparam int NW = 8, NG = 10, NO = 6, NL = 10, U = NO + NL, PW = NW * U + NG;

  typedef struct {
    logic [31:0] ea, eb;
    logic eo, eu;
    string tag;
  } exp_t;

  exp_t sbq[$];
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  logic clk = 0, rst_n = 0;
  logic call = 0, ret = 0, we = 0;
  logic [4:0] wa = 0, ra = 0, rb = 0;
  logic [31:0] wd = 0, rda, rdb;
  logic ovf, unf;

  logic s_call = 0, s_ret = 0, s_we = 0;
  logic [4:0] s_wa = 0, s_ra = 0, s_rb = 0;
  logic [31:0] s_wd = 0, s_rda, s_rdb;
  logic s_ovf, s_unf;

  always #10 clk = ~clk;

  rwin_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .call_i(call), .ret_i(ret),
    .ra_addr(ra), .rb_addr(rb), .wr_en(we), .wr_addr(wa), .wr_data(wd),
    .ra_data(rda), .rb_data(rdb), .ovf_o(ovf), .unf_o(unf)
  );

  rwin_regfile #(.NWIN(6), .NGLOB(18), .NOVL(4), .NLOC(6)) u_dut_s (
    .clk(clk), .rst_n(rst_n), .call_i(s_call), .ret_i(s_ret),
    .ra_addr(s_ra), .rb_addr(s_rb), .wr_en(s_we), .wr_addr(s_wa), .wr_data(s_wd),
    .ra_data(s_rda), .rb_data(s_rdb), .ovf_o(s_ovf), .unf_o(s_unf)
  );

  // Bench model: outgoing k of window w is treated as incoming k of window w+1
  logic [31:0] mem_m [PW];
  int cwp_m, cnt_m;

  function automatic int bmap(int lr, int w);
    int r, ww;
    r = lr; ww = w;
    if (r < NG) return NW * U + r;
    if (r >= NG + NO + NL) begin
      r = r - (NO + NL);
      ww = (ww + 1) % NW;
    end
    return ww * U + (r - NG);
  endfunction

  function automatic logic [31:0] mread(int lr);
    return (lr == 0) ? 32'h0 : mem_m[bmap(lr, cwp_m)];
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Driver: one cycle of stimulus, expected results pushed to the scoreboard
  task automatic step(bit c, bit r, bit w_en, int wa_, logic [31:0] wd_,
                      int ra_, int rb_, string tag);
    exp_t e;
    @(negedge clk);
    call = c; ret = r; we = w_en; wa = 5'(wa_); wd = wd_; ra = 5'(ra_); rb = 5'(rb_);
    e.ea = mread(ra_);
    e.eb = mread(rb_);
    e.eo = c && !r && (cnt_m == NW - 1);
    e.eu = r && !c && (cnt_m == 1);
    e.tag = tag;
    sbq.push_back(e);
    if (w_en && wa_ != 0) mem_m[bmap(wa_, cwp_m)] = wd_;
    if (c && !r && cnt_m != NW - 1) begin cwp_m = (cwp_m + 1) % NW; cnt_m++; end
    else if (r && !c && cnt_m != 1) begin cwp_m = (cwp_m + NW - 1) % NW; cnt_m--; end
  endtask

  task automatic rd(int ra_, int rb_, string tag);
    step(0, 0, 0, 0, 0, ra_, rb_, tag);
  endtask

  task automatic wr(int wa_, logic [31:0] wd_, string tag);
    step(0, 0, 1, wa_, wd_, 0, 0, tag);
  endtask

  // Monitor: compare outputs midway between edges
  initial begin
    forever begin
      exp_t e;
      @(negedge clk);
      #5;
      if (sbq.size() > 0) begin
        e = sbq.pop_front();
        chk(e.tag, "port A", rda, e.ea);
        chk(e.tag, "port B", rdb, e.eb);
        chk(e.tag, "ovf", {31'b0, ovf}, {31'b0, e.eo});
        chk(e.tag, "unf", {31'b0, unf}, {31'b0, e.eu});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < PW; i++) mem_m[i] = 0;
    cwp_m = 0; cnt_m = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;

    rd(12, 20, "R1");
    rd(31, 5, "R1");
    step(0, 1, 0, 0, 0, 16, 10, "R9");              // return at depth one
    wr(16, 32'hA0A0_0016, "R4");
    step(0, 0, 1, 0, 32'hFFFF_FFFF, 0, 0, "R2");    // write to logical 0
    rd(0, 16, "R2");
    wr(5, 32'h6100_0005, "R3");
    wr(26, 32'h0E00_001A, "R5");
    wr(31, 32'h0E00_001F, "R5");
    step(1, 0, 0, 0, 0, 16, 26, "R7");              // strobe cycle still sees window 0
    rd(10, 15, "R5");
    rd(16, 5, "R4");
    rd(1, 5, "R3");
    wr(10, 32'h5E70_000A, "R6");
    wr(16, 32'h1111_0016, "R4");
    step(0, 1, 0, 0, 0, 16, 10, "R7");
    rd(26, 16, "R6");
    rd(31, 10, "R6");
    step(0, 0, 1, 20, 32'h2020_2020, 20, 20, "R7"); // read before same-cycle write
    rd(20, 0, "R7");
    for (int k = 0; k < NW - 2; k++) step(1, 0, 0, 0, 0, 16, 5, "R8");
    step(1, 0, 0, 0, 0, 16, 5, "R8");               // refused call
    rd(16, 5, "R8");
    wr(16, 32'h7777_0016, "R10");
    step(1, 1, 0, 0, 0, 16, 10, "R10");
    rd(16, 10, "R10");
    step(1, 1, 0, 0, 0, 16, 10, "R10");
    for (int k = 0; k < NW - 2; k++) step(0, 1, 0, 0, 0, 16, 26, "R6");
    rd(16, 26, "R4");
    step(0, 1, 0, 0, 0, 16, 26, "R9");              // return at depth one again
    rd(16, 20, "R9");
    @(negedge clk);
    call = 0; ret = 0; we = 0;
    repeat (3) @(negedge clk);

    // Small shape: 6 windows, 18 globals, overlap 4, locals 6
    @(negedge clk); s_we = 1; s_wa = 17; s_wd = 32'h5171_0017;
    @(negedge clk); s_wa = 28; s_wd = 32'h5282_001C;
    @(negedge clk); s_we = 0; s_call = 1;
    @(negedge clk); s_call = 0; s_ra = 17; s_rb = 18;
    #5;
    chk("R11", "global 17 after call", s_rda, 32'h5171_0017);
    chk("R11", "incoming 18 after call", s_rdb, 32'h5282_001C);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); s_call = 1;
      #5; chk("R11", "ovf before limit", {31'b0, s_ovf}, 32'h0);
    end
    @(negedge clk); s_call = 1;
    #5; chk("R11", "ovf at sixth window", {31'b0, s_ovf}, 32'h1);
    @(negedge clk); s_call = 0;
    #5; chk("R11", "global 17 deep", s_rda, 32'h5171_0017);

    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule